// File: doc/BRIEF.md
# Tagged Associative Address Translation Buffer

This block is a small, fully associative cache of page mappings. Each request brings a virtual address, an access kind (read, write or execute) and is matched against the current process tag. A lookup is resolved in the cycle it is presented. One clock later the block returns the physical address, a hit flag and a fault class.

Each entry holds a virtual page number, a physical frame number, a process tag, three permission bits, and status bits that record use and modification. A lookup that finds no valid entry with the same page and tag raises a miss trap. The refill then happens outside the block, through the install port.

Three ways of retiring stale mappings on a context switch are offered:
- a full flush;
- a command that clears every valid bit;
- per-entry process tags, which let mappings of several processes live side by side. A per-process invalidate command removes the mappings of one process only.

Top module: `xlat_tlb`

## Requirements
- R1: After reset no entry is valid, so every lookup misses. The process-id register reads zero, so entries installed with tag 0 hit without first loading the register. rsp_valid is 0.
- R2: A lookup presented with lk_req high in one cycle is answered by rsp_valid high for exactly one cycle after the next rising clock edge. A cycle without lk_req produces rsp_valid low on the next edge.
- R3: A hit needs a valid entry whose page number equals lk_va[VA_W-1:OFF_W] and whose tag equals the process-id register (OFF_W is 12 by default). On a permitted hit, rsp_hit is 1, rsp_fault is 2'b00 and rsp_pa is {frame, lk_va[OFF_W-1:0]}.
- R4: When no entry matches, the response is rsp_fault = 2'b01 and rsp_trap = 1. rsp_hit, rsp_pa, rsp_dirty and rsp_ref are 0.
- R5: Access kinds are encoded on lk_kind as 00 read, 01 write, 10 execute, and 11 reserved (never allowed). Permission bits are ins_perm[0] read, [1] write and [2] execute. A matching entry that does not allow the kind gives rsp_fault = 2'b10, with hit, trap and PA all 0. A miss always reports 2'b01, never 2'b10.
- R6: rsp_dirty and rsp_ref report the entry's status bits as they stood before a permitted hit. Every permitted hit sets the entry's referenced bit, and a permitted write hit sets its dirty bit. A faulting access changes neither bit. An install loads dirty from ins_dirty and clears referenced.
- R7: The install slot is chosen in this order:
  - a valid entry with the same page and tag is overwritten in place;
  - otherwise the lowest-numbered invalid entry is used;
  - otherwise the entry at a round-robin pointer is replaced. The pointer is 0 after reset and advances by one, modulo ENTRIES, only on such a replacement.
- R8: flush_all empties every entry, so all later lookups miss until a new install.
- R9: clr_valid clears the valid bit of every entry, so all later lookups miss.
- R10: inv_en clears only the entries whose tag equals inv_pid. Entries with other tags keep hitting.
- R11: pid_set loads pid_val into the process-id register, and lookups from the next cycle use it. Entries tagged with another id then miss, and become reachable again when that id is loaded back.
- R12: An install in the same cycle as flush_all, clr_valid or inv_en is discarded and does not move the round-robin pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address of the lookup |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| pid_set | input | 1 | Load the process-id register |
| pid_val | input | PID_W | Value for the process-id register |
| ins_en | input | 1 | Install an entry |
| ins_vpn | input | VA_W-OFF_W | Page number to install |
| ins_pfn | input | PA_W-OFF_W | Frame number to install |
| ins_pid | input | PID_W | Process tag of the installed entry |
| ins_perm | input | 3 | Permissions: bit 0 read, 1 write, 2 execute |
| ins_dirty | input | 1 | Initial dirty bit |
| flush_all | input | 1 | Empty every entry |
| clr_valid | input | 1 | Clear every valid bit |
| inv_en | input | 1 | Invalidate the entries of one process |
| inv_pid | input | PID_W | Process tag to invalidate |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Permitted translation delivered |
| rsp_fault | output | 2 | 00 none, 01 miss, 10 protection |
| rsp_pa | output | PA_W | Physical address, zero when not a hit |
| rsp_trap | output | 1 | Miss trap request |
| rsp_dirty | output | 1 | Entry dirty bit before this access |
| rsp_ref | output | 1 | Entry referenced bit before this access |

## Verification
A corrupted page, frame or tag field shows up on the response to the very next lookup of that page: a miss where a hit was due, or a wrong rsp_pa. A permission bit stored in the wrong place shows as a wrong fault class for one particular access kind. Because the bench runs every access kind over every page, such errors cannot hide behind a single chosen pattern. A wrong replacement pointer, or a status bit that was not updated, is invisible until a later install or a later hit on that entry. The sweeps therefore repeat after each install and each invalidation command, which brings such faults out within one sweep.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_MISS = 2'b01,
    FLT_PROT = 2'b10
  } fault_e;

  localparam int PERM_BITS = 3;

  // permission bit 0 read, 1 write, 2 execute; reserved kind never allowed
  function automatic logic perm_allows(input logic [PERM_BITS-1:0] perm,
                                       input logic [1:0] kind);
    case (kind)
      ACC_READ:  return perm[0];
      ACC_WRITE: return perm[1];
      ACC_EXEC:  return perm[2];
      default:   return 1'b0;
    endcase
  endfunction

  function automatic fault_e classify(input logic found, input logic allowed);
    if (!found)        return FLT_MISS;
    else if (!allowed) return FLT_PROT;
    else               return FLT_NONE;
  endfunction

endpackage

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int N     = 64,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int PID_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush_all,
  input  logic                 clr_valid,
  input  logic                 inv_en,
  input  logic [PID_W-1:0]     inv_pid,
  input  logic                 ins_fire,
  input  logic [IDX_W-1:0]     ins_idx,
  input  logic [VPN_W-1:0]     ins_vpn,
  input  logic [PFN_W-1:0]     ins_pfn,
  input  logic [PID_W-1:0]     ins_pid,
  input  logic [PERM_BITS-1:0] ins_perm,
  input  logic                 ins_dirty,
  input  logic                 upd_en,
  input  logic [IDX_W-1:0]     upd_idx,
  input  logic                 upd_dirty,
  output logic [N-1:0]         valid_q,
  output logic [VPN_W-1:0]     vpn_q   [N],
  output logic [PFN_W-1:0]     pfn_q   [N],
  output logic [PID_W-1:0]     pid_q   [N],
  output logic [PERM_BITS-1:0] perm_q  [N],
  output logic                 dirty_q [N],
  output logic                 ref_q   [N]
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < N; i++) begin
        vpn_q[i]   <= '0;
        pfn_q[i]   <= '0;
        pid_q[i]   <= '0;
        perm_q[i]  <= '0;
        dirty_q[i] <= 1'b0;
        ref_q[i]   <= 1'b0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (flush_all) begin
          valid_q[i] <= 1'b0;
          vpn_q[i]   <= '0;
          pfn_q[i]   <= '0;
          pid_q[i]   <= '0;
          perm_q[i]  <= '0;
          dirty_q[i] <= 1'b0;
          ref_q[i]   <= 1'b0;
        end else if (clr_valid) begin
          valid_q[i] <= 1'b0;
        end else if (inv_en && (pid_q[i] == inv_pid)) begin
          valid_q[i] <= 1'b0;
        end else if (ins_fire && (ins_idx == IDX_W'(i))) begin
          valid_q[i] <= 1'b1;
          vpn_q[i]   <= ins_vpn;
          pfn_q[i]   <= ins_pfn;
          pid_q[i]   <= ins_pid;
          perm_q[i]  <= ins_perm;
          dirty_q[i] <= ins_dirty;
          ref_q[i]   <= 1'b0;
        end else if (upd_en && (upd_idx == IDX_W'(i))) begin
          ref_q[i]   <= 1'b1;
          dirty_q[i] <= dirty_q[i] | upd_dirty;
        end
      end
    end
  end

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0));

  // R9
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> (valid_q == '0));

  for (genvar g = 0; g < N; g++) begin : g_inv_chk
    // R10
    inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en && (pid_q[g] == inv_pid)) |=> !valid_q[g]);
  end

endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N     = 64,
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_q,
  input  logic [VPN_W-1:0] vpn_q [N],
  input  logic [PID_W-1:0] pid_q [N],
  input  logic [VPN_W-1:0] key_vpn,
  input  logic [PID_W-1:0] key_pid,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PID_W-1:0] ins_pid,
  output logic [N-1:0]     lk_match_vec,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [N-1:0]     ins_match_vec,
  output logic             ins_hit,
  output logic [IDX_W-1:0] ins_midx
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign lk_match_vec[g]  = valid_q[g] && (vpn_q[g] == key_vpn) && (pid_q[g] == key_pid);
    assign ins_match_vec[g] = valid_q[g] && (vpn_q[g] == ins_vpn) && (pid_q[g] == ins_pid);
  end

  assign lk_hit  = |lk_match_vec;
  assign ins_hit = |ins_match_vec;

  always_comb begin
    lk_idx   = '0;
    ins_midx = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_match_vec[i])  lk_idx   = IDX_W'(i);
      if (ins_match_vec[i]) ins_midx = IDX_W'(i);
    end
  end

  // R3 (install overwrite rule keeps page+tag unique)
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match_vec));

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N = 64,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_fire,
  input  logic [N-1:0]     valid_q,
  input  logic             ins_hit,
  input  logic [IDX_W-1:0] ins_midx,
  output logic [IDX_W-1:0] victim_idx
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;
  logic             rr_used;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
  end

  assign free_any = ~&valid_q;
  assign rr_used  = ins_fire && !ins_hit && !free_any;

  always_comb begin
    if (ins_hit)       victim_idx = ins_midx;
    else if (free_any) victim_idx = free_idx;
    else               victim_idx = rr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rr_q <= '0;
    else if (rr_used) rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  // R7
  victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && !ins_hit && free_any) |-> !valid_q[victim_idx]);

  // R7
  rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rr_used |=> $stable(rr_q));

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PID_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_req,
  input  logic [VA_W-1:0]         lk_va,
  input  logic [1:0]              lk_kind,
  input  logic                    pid_set,
  input  logic [PID_W-1:0]        pid_val,
  input  logic                    ins_en,
  input  logic [VA_W-OFF_W-1:0]   ins_vpn,
  input  logic [PA_W-OFF_W-1:0]   ins_pfn,
  input  logic [PID_W-1:0]        ins_pid,
  input  logic [2:0]              ins_perm,
  input  logic                    ins_dirty,
  input  logic                    flush_all,
  input  logic                    clr_valid,
  input  logic                    inv_en,
  input  logic [PID_W-1:0]        inv_pid,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic [1:0]              rsp_fault,
  output logic [PA_W-1:0]         rsp_pa,
  output logic                    rsp_trap,
  output logic                    rsp_dirty,
  output logic                    rsp_ref
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [PA_W-1:0] join_pa(input logic [PFN_W-1:0] frame,
                                               input logic [VA_W-1:0]  va);
    return {frame, va[OFF_W-1:0]};
  endfunction

  // process-id register
  logic [PID_W-1:0] cur_pid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_pid <= '0;
    else if (pid_set) cur_pid <= pid_val;
  end

  // entry state
  logic [ENTRIES-1:0]     valid_q;
  logic [VPN_W-1:0]       vpn_q   [ENTRIES];
  logic [PFN_W-1:0]       pfn_q   [ENTRIES];
  logic [PID_W-1:0]       pid_q   [ENTRIES];
  logic [PERM_BITS-1:0]   perm_q  [ENTRIES];
  logic                   dirty_q [ENTRIES];
  logic                   ref_q   [ENTRIES];

  // named internal events
  logic                   any_cmd;
  logic                   ins_fire;
  logic [VPN_W-1:0]       key_vpn;
  logic [ENTRIES-1:0]     lk_match_vec;
  logic                   lk_hit;
  logic [IDX_W-1:0]       lk_idx;
  logic [ENTRIES-1:0]     ins_match_vec;
  logic                   ins_hit;
  logic [IDX_W-1:0]       ins_midx;
  logic [IDX_W-1:0]       victim_idx;
  logic                   lk_ok;
  fault_e                 lk_fault;
  logic                   upd_en;
  logic                   upd_dirty;

  assign any_cmd   = flush_all | clr_valid | inv_en;
  assign ins_fire  = ins_en & ~any_cmd;
  assign key_vpn   = lk_va[VA_W-1:OFF_W];
  assign lk_ok     = lk_hit && perm_allows(perm_q[lk_idx], lk_kind);
  assign lk_fault  = classify(lk_hit, lk_ok);
  assign upd_en    = lk_req && lk_ok;
  assign upd_dirty = (lk_kind == ACC_WRITE);

  xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_match (
    .clk           (clk),
    .rst_n         (rst_n),
    .valid_q       (valid_q),
    .vpn_q         (vpn_q),
    .pid_q         (pid_q),
    .key_vpn       (key_vpn),
    .key_pid       (cur_pid),
    .ins_vpn       (ins_vpn),
    .ins_pid       (ins_pid),
    .lk_match_vec  (lk_match_vec),
    .lk_hit        (lk_hit),
    .lk_idx        (lk_idx),
    .ins_match_vec (ins_match_vec),
    .ins_hit       (ins_hit),
    .ins_midx      (ins_midx)
  );

  xlat_victim #(.N(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_fire   (ins_fire),
    .valid_q    (valid_q),
    .ins_hit    (ins_hit),
    .ins_midx   (ins_midx),
    .victim_idx (victim_idx)
  );

  xlat_store #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_all (flush_all),
    .clr_valid (clr_valid),
    .inv_en    (inv_en),
    .inv_pid   (inv_pid),
    .ins_fire  (ins_fire),
    .ins_idx   (victim_idx),
    .ins_vpn   (ins_vpn),
    .ins_pfn   (ins_pfn),
    .ins_pid   (ins_pid),
    .ins_perm  (ins_perm),
    .ins_dirty (ins_dirty),
    .upd_en    (upd_en),
    .upd_idx   (lk_idx),
    .upd_dirty (upd_dirty),
    .valid_q   (valid_q),
    .vpn_q     (vpn_q),
    .pfn_q     (pfn_q),
    .pid_q     (pid_q),
    .perm_q    (perm_q),
    .dirty_q   (dirty_q),
    .ref_q     (ref_q)
  );

  // registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= FLT_NONE;
      rsp_pa    <= '0;
      rsp_trap  <= 1'b0;
      rsp_dirty <= 1'b0;
      rsp_ref   <= 1'b0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req && lk_ok;
      rsp_fault <= lk_req ? lk_fault : FLT_NONE;
      rsp_pa    <= (lk_req && lk_ok) ? join_pa(pfn_q[lk_idx], lk_va) : '0;
      rsp_trap  <= lk_req && !lk_hit;
      rsp_dirty <= lk_req && lk_ok && dirty_q[lk_idx];
      rsp_ref   <= lk_req && lk_ok && ref_q[lk_idx];
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (!rsp_hit || (rsp_pa[OFF_W-1:0] == $past(lk_va[OFF_W-1:0]))));

  // R4
  miss_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> (rsp_valid && !rsp_hit && (rsp_fault == FLT_MISS) && (rsp_pa == '0)));

  // R5
  miss_before_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !lk_hit) |=> (rsp_fault == FLT_MISS));

  // R6
  write_marks_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_dirty && !any_cmd && !ins_fire) |=> dirty_q[$past(lk_idx)]);

  // R11
  pid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pid_set |=> (cur_pid == $past(pid_val)));

endmodule

// File: tb/xlat_tlb_bench.sv
module xlat_tlb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int VA_W  = 32;
  localparam int PA_W  = 32;
  localparam int OFF_W = 12;
  localparam int PID_W = 4;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_req = 1'b0;
  logic [VA_W-1:0] lk_va = '0;
  logic [1:0] lk_kind = '0;
  logic pid_set = 1'b0;
  logic [PID_W-1:0] pid_val = '0;
  logic ins_en = 1'b0;
  logic [VPN_W-1:0] ins_vpn = '0;
  logic [PFN_W-1:0] ins_pfn = '0;
  logic [PID_W-1:0] ins_pid = '0;
  logic [2:0] ins_perm = '0;
  logic ins_dirty = 1'b0;
  logic flush_all = 1'b0;
  logic clr_valid = 1'b0;
  logic inv_en = 1'b0;
  logic [PID_W-1:0] inv_pid = '0;
  logic rsp_valid, rsp_hit, rsp_trap, rsp_dirty, rsp_ref;
  logic [1:0] rsp_fault;
  logic [PA_W-1:0] rsp_pa;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_tlb #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .PID_W(PID_W)) u_xlat_tlb (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_kind(lk_kind),
    .pid_set(pid_set), .pid_val(pid_val), .ins_en(ins_en), .ins_vpn(ins_vpn),
    .ins_pfn(ins_pfn), .ins_pid(ins_pid), .ins_perm(ins_perm), .ins_dirty(ins_dirty),
    .flush_all(flush_all), .clr_valid(clr_valid), .inv_en(inv_en), .inv_pid(inv_pid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .rsp_trap(rsp_trap), .rsp_dirty(rsp_dirty), .rsp_ref(rsp_ref)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench-side mapping table
  logic             m_val   [N];
  logic [VPN_W-1:0] m_vpn   [N];
  logic [PFN_W-1:0] m_pfn   [N];
  logic [PID_W-1:0] m_pid   [N];
  logic [2:0]       m_perm  [N];
  logic             m_dirty [N];
  logic             m_ref   [N];
  int               m_rr;
  logic [PID_W-1:0] m_cur;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [PFN_W-1:0] frame_of(input int v);
    return PFN_W'((v * 4099 + 291) & 20'hFFFFF);
  endfunction

  task automatic lookup(input logic [VA_W-1:0] va, input logic [1:0] kind, input string ctx);
    int j;
    logic ok;
    logic [63:0] exp;
    string tag;
    @(negedge clk);
    lk_req = 1'b1; lk_va = va; lk_kind = kind;
    j = -1;
    for (int e = 0; e < N; e++)
      if (m_val[e] && m_vpn[e] == va[VA_W-1:OFF_W] && m_pid[e] == m_cur) j = e;
    // pack: valid, hit, fault[1:0], trap, dirty, ref, pa
    if (j < 0) begin
      exp = {25'd0, 1'b1, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 32'd0};
      tag = "R4 miss";
    end else begin
      case (kind)
        2'b00: ok = m_perm[j][0];
        2'b01: ok = m_perm[j][1];
        2'b10: ok = m_perm[j][2];
        default: ok = 1'b0;
      endcase
      if (!ok) begin
        exp = {25'd0, 1'b1, 1'b0, 2'b10, 1'b1 & 1'b0, 1'b0, 1'b0, 32'd0};
        tag = "R5 protection";
      end else begin
        exp = {25'd0, 1'b1, 1'b1, 2'b00, 1'b0, m_dirty[j], m_ref[j], m_pfn[j], va[OFF_W-1:0]};
        tag = "R3 R6 hit";
        m_ref[j] = 1'b1;
        if (kind == 2'b01) m_dirty[j] = 1'b1;
      end
    end
    @(negedge clk);
    lk_req = 1'b0;
    check($sformatf("%s %s va=%h kind=%0d", ctx, tag, va, kind),
          {25'd0, rsp_valid, rsp_hit, rsp_fault, rsp_trap, rsp_dirty, rsp_ref, rsp_pa}, exp);
    @(negedge clk);
    check({ctx, " R2 response lasts one cycle"}, {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic sweep(input string ctx);
    for (int v = 0; v < 12; v++)
      for (int k = 0; k < 4; k++)
        lookup({VPN_W'(v), OFF_W'((v * 291 + k * 83) & 12'hFFF)}, 2'(k), ctx);
  endtask

  task automatic install(input int v, input logic [PFN_W-1:0] f, input logic [PID_W-1:0] p,
                         input logic [2:0] perm, input logic d, input logic with_flush);
    int j;
    @(negedge clk);
    ins_en = 1'b1; ins_vpn = VPN_W'(v); ins_pfn = f; ins_pid = p; ins_perm = perm; ins_dirty = d;
    flush_all = with_flush;
    if (with_flush) begin
      for (int e = 0; e < N; e++) m_val[e] = 1'b0;
    end else begin
      j = -1;
      for (int e = 0; e < N; e++) if (m_val[e] && m_vpn[e] == VPN_W'(v) && m_pid[e] == p) j = e;
      if (j < 0) for (int e = N - 1; e >= 0; e--) if (!m_val[e]) j = e;
      if (j < 0) begin j = m_rr; m_rr = (m_rr + 1) % N; end
      m_val[j] = 1'b1; m_vpn[j] = VPN_W'(v); m_pfn[j] = f; m_pid[j] = p;
      m_perm[j] = perm; m_dirty[j] = d; m_ref[j] = 1'b0;
    end
    @(negedge clk);
    ins_en = 1'b0; flush_all = 1'b0;
  endtask

  task automatic cmd_flush();
    @(negedge clk); flush_all = 1'b1;
    for (int e = 0; e < N; e++) m_val[e] = 1'b0;
    @(negedge clk); flush_all = 1'b0;
  endtask

  task automatic cmd_clear();
    @(negedge clk); clr_valid = 1'b1;
    for (int e = 0; e < N; e++) m_val[e] = 1'b0;
    @(negedge clk); clr_valid = 1'b0;
  endtask

  task automatic cmd_inv(input logic [PID_W-1:0] p);
    @(negedge clk); inv_en = 1'b1; inv_pid = p;
    for (int e = 0; e < N; e++) if (m_pid[e] == p) m_val[e] = 1'b0;
    @(negedge clk); inv_en = 1'b0;
  endtask

  task automatic set_pid(input logic [PID_W-1:0] p);
    @(negedge clk); pid_set = 1'b1; pid_val = p; m_cur = p;
    @(negedge clk); pid_set = 1'b0;
  endtask

  initial begin
    for (int e = 0; e < N; e++) begin
      m_val[e] = 1'b0; m_vpn[e] = '0; m_pfn[e] = '0; m_pid[e] = '0;
      m_perm[e] = '0; m_dirty[e] = 1'b0; m_ref[e] = 1'b0;
    end
    m_rr = 0; m_cur = '0;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    sweep("R1 empty");

    // fill with tag 0 (register still at reset value)
    install(1, frame_of(1), 4'd0, 3'b111, 1'b0, 1'b0);
    install(2, frame_of(2), 4'd0, 3'b001, 1'b1, 1'b0);
    install(3, frame_of(3), 4'd0, 3'b011, 1'b0, 1'b0);
    install(4, frame_of(4), 4'd0, 3'b101, 1'b0, 1'b0);
    sweep("R1 R3 first pass");
    sweep("R6 second pass");

    // R7 replacement and in-place overwrite
    install(9, frame_of(9), 4'd0, 3'b010, 1'b0, 1'b0);
    install(3, frame_of(33), 4'd0, 3'b100, 1'b1, 1'b0);
    install(10, frame_of(10), 4'd0, 3'b111, 1'b0, 1'b0);
    sweep("R7 after replacement");

    // R11 switch process id
    set_pid(4'd5);
    sweep("R11 pid 5 empty");
    install(2, frame_of(52), 4'd5, 3'b011, 1'b0, 1'b0);
    install(7, frame_of(57), 4'd5, 3'b001, 1'b0, 1'b0);
    sweep("R11 pid 5");
    set_pid(4'd0);
    sweep("R11 pid 0 again");

    // R10 per-process invalidate
    cmd_inv(4'd5);
    sweep("R10 pid 0 kept");
    set_pid(4'd5);
    sweep("R10 pid 5 removed");
    set_pid(4'd0);

    // R9 clear valid bits
    cmd_clear();
    sweep("R9 cleared");
    install(5, frame_of(5), 4'd0, 3'b111, 1'b0, 1'b0);
    install(6, frame_of(6), 4'd0, 3'b110, 1'b0, 1'b0);
    sweep("R7 R9 refill lowest free");

    // R12 install together with flush is dropped
    install(8, frame_of(8), 4'd0, 3'b111, 1'b0, 1'b1);
    sweep("R12 install dropped by flush");

    // R8 flush after a fill
    install(11, frame_of(11), 4'd0, 3'b111, 1'b1, 1'b0);
    install(1, frame_of(21), 4'd0, 3'b111, 1'b0, 1'b0);
    sweep("R8 before flush");
    cmd_flush();
    sweep("R8 after flush");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule